// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is the slave end of an I2C-style two-wire bus. It watches the clock and data lines, oversampled by a much faster system clock, and recognises START, repeated START and STOP. It answers one 7-bit bus address. The upper four bits of that address are a fixed identifier. The lower three bits come from a device-address register that the master can rewrite over the bus. A master selects a register with a command byte and then writes or reads one or two data bytes, most significant byte first. The slave drives the data line open-drain: it either pulls the line low or releases it. It uses this to acknowledge bytes and to send read data.

A write that supplies every byte of a known register and then ends with STOP raises a one-cycle commit strobe. The strobe goes to a model of a nonvolatile store. The model reports busy for a fixed number of cycles. While busy is high, the slave refuses everything on the bus, including its own address. The two-byte register is updated only when both of its bytes are present, so a reader never sees a half-written value.

Top module: `twsr_slave`

## Requirements
- R1: After reset, the slave releases SDA (`sda_pull`=0). The offset, level and device-address registers are zero, and `nv_busy` is 0.
- R2: The address byte carries identifier 1011 in bits 7:4, the device address in bits 3:1 and R/W in bit 0 (1 means read). The slave ACKs only when the identifier and device address both match. After a mismatch, the slave ignores the bus until the next START.
- R3: An ACK is SDA held low through the high phase of the ninth clock. The slave ACKs the matched address byte, the command byte and every data byte written to it. SDA is changed only while SCL is low.
- R4: Command 0Eh selects the one-byte offset register. Command 0Dh selects the device-address register, which keeps bits 2:0 of its data byte. A new device address takes effect for later transfers.
- R5: Command 08h selects the two-byte level register, written MSB first then LSB. The MSB is staged, and the visible value changes only when the LSB arrives, with both bytes updated together.
- R6: A read is: address byte with R/W=0, command byte, repeated START, address byte with R/W=1. The slave then sends the selected register MSB first. It sends the next byte after each master ACK and releases SDA after a master NACK. Bytes past the register length, and reads of unknown commands, return FFh.
- R7: When a write has supplied all bytes of a known register and ends with STOP, the slave commits it. `nv_busy` is then high for NV_CYCLES cycles, and during that time every byte, including the address byte, is NACKed.
- R8: A write to an unknown command is ACKed but discarded and causes no commit. A write cut short before its last byte causes no commit.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts the address phase without passing through STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| offset_val | output | 8 | Offset register contents |
| level_val | output | 16 | Two-byte level register contents |
| nv_busy | output | 1 | Nonvolatile write in progress |

## Verification
All 256 values of the first byte after START are swept. Only the matching write and read codes may be ACKed, which separates identifier decode, device-address decode and R/W handling. After the device address is rewritten, the eight device-address values are swept again, showing that the match follows the register and not a constant. Complete, truncated and unknown-command writes tell commit from no commit. The level register is observed between its two bytes, which shows the update is atomic. Reads of one, two and three bytes, each ending in a master NACK, cover the byte order, the FFh padding and the release of SDA. An address attempt made during busy, followed by one made after busy ends, shows both the refusal and the recovery.

// File: rtl/twsr_pkg.sv
// Shared types and command codes for the two-wire slave.
// Assumes byte-wide commands; register lengths are at most two bytes.
package twsr_pkg;
    localparam int ADR_BITS = 3;
    localparam logic [7:0] CMD_OFS = 8'h0E;
    localparam logic [7:0] CMD_LVL = 8'h08;
    localparam logic [7:0] CMD_ADR = 8'h0D;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACKW, ST_ACKH, ST_TX, ST_TACK, ST_TACKF
    } link_st_t;

    typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} phase_t;

    // Number of data bytes a command owns; 0 for unknown commands.
    function automatic logic [1:0] reg_len(input logic [7:0] c);
        case (c)
            CMD_OFS: reg_len = 2'd1;
            CMD_LVL: reg_len = 2'd2;
            CMD_ADR: reg_len = 2'd1;
            default: reg_len = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/twsr_busin.sv
// Synchronizes SCL and SDA into clk and derives edge and START/STOP events.
// Assumes clk is at least 16 times the SCL rate; idle bus level is high.
module twsr_busin (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    logic [LINES-1:0] raw, meta, sync, prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Two-flop synchronizer plus one history flop per line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[g] <= 1'b1;
                sync[g] <= 1'b1;
                prev[g] <= 1'b1;
            end else begin
                meta[g] <= raw[g];
                sync[g] <= meta[g];
                prev[g] <= sync[g];
            end
        end
    end

    assign scl_lvl   = sync[0];
    assign sda_lvl   = sync[1];
    assign scl_rise  = sync[0] & ~prev[0];
    assign scl_fall  = ~sync[0] & prev[0];
    assign start_det = sync[0] & prev[0] & prev[1] & ~sync[1];
    assign stop_det  = sync[0] & prev[0] & ~prev[1] & sync[1];
endmodule

// File: rtl/twsr_link.sv
// Bus protocol sequencer: address match, command capture, write data, read data,
// ACK/NACK and commit on STOP. Assumes bus events from twsr_busin.
module twsr_link #(
    parameter logic [3:0] DEV_ID = 4'b1011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_lvl,
    input  logic                          sda_lvl,
    input  logic                          scl_rise,
    input  logic                          scl_fall,
    input  logic                          start_det,
    input  logic                          stop_det,
    input  logic [twsr_pkg::ADR_BITS-1:0] dev_addr,
    input  logic                          nv_busy,
    input  logic [7:0]                    rd_byte,
    output logic                          sda_pull,
    output logic                          wr_en,
    output logic [1:0]                    wr_idx,
    output logic [7:0]                    wr_data,
    output logic [7:0]                    cmd_q,
    output logic [1:0]                    idx_q,
    output logic                          commit
);
    import twsr_pkg::*;

    link_st_t   st;
    phase_t     phase;
    logic [2:0] bitcnt;
    logic [7:0] sh;
    logic       ackgo, rw_q, done_q, pull_q;
    logic [7:0] nb;
    logic [1:0] idx_inc;

    assign nb       = {sh[6:0], sda_lvl};
    assign idx_inc  = (idx_q == 2'd3) ? idx_q : idx_q + 2'd1;
    assign sda_pull = pull_q;

    // Main sequencer: START/STOP take priority over per-bit progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; phase <= PH_ADDR; bitcnt <= '0; sh <= '0;
            ackgo <= 1'b0; rw_q <= 1'b0; done_q <= 1'b0; pull_q <= 1'b0;
            wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0; cmd_q <= '0;
            idx_q <= '0; commit <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            commit <= 1'b0;
            if (start_det) begin
                st <= ST_RX; phase <= PH_ADDR; bitcnt <= '0;
                pull_q <= 1'b0; done_q <= 1'b0;
            end else if (stop_det) begin
                st <= ST_IDLE; pull_q <= 1'b0; done_q <= 1'b0;
                commit <= done_q;
            end else begin
                case (st)
                    ST_RX: if (scl_rise) begin
                        sh <= nb;
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            st <= ST_ACKW;
                            case (phase)
                                PH_ADDR: begin
                                    ackgo <= (nb[7:4] == DEV_ID) && (nb[3:1] == dev_addr) && !nv_busy;
                                    rw_q  <= nb[0];
                                    idx_q <= '0;
                                end
                                PH_CMD: begin
                                    ackgo <= !nv_busy;
                                    if (!nv_busy) begin
                                        cmd_q <= nb;
                                        idx_q <= '0;
                                    end
                                end
                                default: begin
                                    ackgo <= !nv_busy;
                                    if (!nv_busy) begin
                                        wr_en   <= 1'b1;
                                        wr_data <= nb;
                                        wr_idx  <= idx_q;
                                        idx_q   <= idx_inc;
                                        if (reg_len(cmd_q) != 2'd0 && idx_q + 2'd1 == reg_len(cmd_q))
                                            done_q <= 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACKW: if (scl_fall) begin
                        pull_q <= ackgo;
                        st <= ST_ACKH;
                    end
                    ST_ACKH: if (scl_fall) begin
                        pull_q <= 1'b0;
                        if (!ackgo) begin
                            st <= ST_IDLE;
                        end else if (phase == PH_ADDR && rw_q) begin
                            sh <= rd_byte; pull_q <= ~rd_byte[7];
                            bitcnt <= '0; st <= ST_TX;
                        end else begin
                            st <= ST_RX;
                            phase <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
                        end
                    end
                    ST_TX: if (scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            pull_q <= 1'b0; bitcnt <= '0; st <= ST_TACK;
                        end else begin
                            sh <= {sh[6:0], 1'b0};
                            pull_q <= ~sh[6];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                    ST_TACK: if (scl_rise) begin
                        if (!sda_lvl) begin
                            idx_q <= idx_inc; st <= ST_TACKF;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_TACKF: if (scl_fall) begin
                        sh <= rd_byte; pull_q <= ~rd_byte[7];
                        bitcnt <= '0; st <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: SDA changes only in a cycle where the synchronized SCL was low.
    a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pull_q) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_lvl));
    // R2: an address ACK only follows a matching address byte.
    a_r2_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACKH && pull_q && phase == PH_ADDR) |-> (sh[7:4] == DEV_ID && sh[3:1] == dev_addr));
    // R7: no ACK is started while the nonvolatile write is busy.
    a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACKH && $rose(pull_q)) |-> !$past(nv_busy));
    // R6: SDA is released while the master acknowledges a sent byte.
    a_r6_release_in_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TACK) |-> !pull_q);
endmodule

// File: rtl/twsr_regfile.sv
// Command-addressed register file with a staged two-byte level register.
// Assumes one write strobe per received data byte; reads are combinational.
module twsr_regfile (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_idx,
    input  logic [7:0]                    wr_data,
    input  logic [7:0]                    cmd,
    input  logic [1:0]                    rd_idx,
    output logic [7:0]                    ofs_q,
    output logic [15:0]                   lvl_q,
    output logic [twsr_pkg::ADR_BITS-1:0] adr_q,
    output logic [7:0]                    rd_byte
);
    import twsr_pkg::*;
    logic [7:0] stage_q;

    // Register writes; the level register commits both bytes at its LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q <= '0; lvl_q <= '0; adr_q <= '0; stage_q <= '0;
        end else if (wr_en) begin
            case (cmd)
                CMD_OFS: if (wr_idx == 2'd0) ofs_q <= wr_data;
                CMD_ADR: if (wr_idx == 2'd0) adr_q <= wr_data[ADR_BITS-1:0];
                CMD_LVL: begin
                    if (wr_idx == 2'd0) stage_q <= wr_data;
                    else if (wr_idx == 2'd1) lvl_q <= {stage_q, wr_data};
                end
                default: ;
            endcase
        end
    end

    // Read byte selection; anything outside a register reads as FFh.
    always_comb begin
        rd_byte = 8'hFF;
        case (cmd)
            CMD_OFS: if (rd_idx == 2'd0) rd_byte = ofs_q;
            CMD_ADR: if (rd_idx == 2'd0) rd_byte = {{(8-ADR_BITS){1'b0}}, adr_q};
            CMD_LVL: begin
                if (rd_idx == 2'd0) rd_byte = lvl_q[15:8];
                else if (rd_idx == 2'd1) rd_byte = lvl_q[7:0];
            end
            default: ;
        endcase
    end

    // R5: the level register changes only on a write of its second byte.
    a_r5_level_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(wr_en && cmd == CMD_LVL && wr_idx == 2'd1));
    // R8: the offset register ignores writes aimed at other commands.
    a_r8_offset_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ofs_q) |-> $past(wr_en && cmd == CMD_OFS));
endmodule

// File: rtl/twsr_nvwait.sv
// Model of the nonvolatile write: busy for NV_CYCLES cycles after a commit.
// Assumes commit never arrives while busy (the link NACKs during busy).
module twsr_nvwait #(
    parameter int NV_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic busy
);
    localparam int CNT_W = $clog2(NV_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    // Load on commit, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (commit)     cnt <= CNT_W'(NV_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: a commit always starts a busy period.
    a_r7_commit_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);
    // R7: commits only arrive while idle.
    a_r7_commit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);
endmodule

// File: rtl/twsr_slave.sv
// Top of the two-wire slave: line conditioning, protocol link, register file
// and nonvolatile-write model. Assumes open-drain bus resolved outside.
module twsr_slave #(
    parameter logic [3:0] DEV_ID    = 4'b1011,
    parameter int         NV_CYCLES = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    output logic [7:0]  offset_val,
    output logic [15:0] level_val,
    output logic        nv_busy
);
    import twsr_pkg::*;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en, commit;
    logic [1:0] wr_idx, idx_q;
    logic [7:0] wr_data, cmd_q, rd_byte;
    logic [ADR_BITS-1:0] adr_q;

    twsr_busin u_busin (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    twsr_link #(.DEV_ID(DEV_ID)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .dev_addr(adr_q), .nv_busy(nv_busy),
        .rd_byte(rd_byte), .sda_pull(sda_pull), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .cmd_q(cmd_q), .idx_q(idx_q),
        .commit(commit)
    );

    twsr_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .cmd(cmd_q), .rd_idx(idx_q), .ofs_q(offset_val),
        .lvl_q(level_val), .adr_q(adr_q), .rd_byte(rd_byte)
    );

    twsr_nvwait #(.NV_CYCLES(NV_CYCLES)) u_nv (
        .clk(clk), .rst_n(rst_n), .commit(commit), .busy(nv_busy)
    );
endmodule

// File: tb/test_twsr_slave.sv
// Bench for twsr_slave: bus-level master model with sweeps and register checks.
module test_twsr_slave;
    localparam int Q  = 8;
    localparam int NV = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_pull, nv_busy;
    logic [7:0] offset_val;
    logic [15:0] level_val;
    logic sda_bus;
    int total = 0;
    int bad = 0;
    logic ended = 1'b0;

    assign sda_bus = msda & ~sda_pull;

    always #2 clk = ~clk;

    twsr_slave #(.NV_CYCLES(NV)) i_twsr_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_pull(sda_pull), .offset_val(offset_val), .level_val(level_val),
        .nv_busy(nv_busy)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        msda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        msda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        msda = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic m, output logic s);
        msda = m; tick(Q); scl = 1'b1; tick(Q);
        s = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 4 * NV && nv_busy; i++) tick(1);
    endtask

    // Write transfer: address, command, n data bytes, STOP; acks are checked.
    task automatic wr_xfer(input logic [7:0] ab, input logic [7:0] cmd,
                           input logic [15:0] d, input int n, input string tag);
        logic a;
        bus_start;
        send_byte(ab, a);  check({tag, " addr ack"}, a, 1);
        send_byte(cmd, a); check({tag, " cmd ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(i == 0 ? d[15:8] : d[7:0], a);
            check({tag, " data ack"}, a, 1);
        end
        bus_stop;
    endtask

    // Read transfer of n bytes; last byte NACKed; values checked against exp.
    task automatic rd_xfer(input logic [7:0] ab, input logic [7:0] cmd, input int n,
                           input logic [23:0] exp, input string tag);
        logic a;
        logic [7:0] b;
        bus_start;
        send_byte(ab, a);  check({tag, " addr ack"}, a, 1);
        send_byte(cmd, a); check({tag, " cmd ack"}, a, 1);
        bus_start;
        send_byte(ab | 8'h01, a); check({tag, " R9 repeated start read ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            check({tag, " data"}, b, exp[23 - 8*i -: 8]);
        end
        check({tag, " R6 release after NACK"}, sda_pull, 0);
        bus_stop;
    endtask

    initial begin
        logic a;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R1 sda released", sda_pull, 0);
        check("R1 offset zero", offset_val, 0);
        check("R1 level zero", level_val, 0);
        check("R1 busy low", nv_busy, 0);

        // R2: sweep every first byte; only B0h/B1h may be acknowledged.
        for (int v = 0; v < 256; v++) begin
            bus_start;
            send_byte(8'(v), a);
            check($sformatf("R2 address sweep %02h", v), a, (v[7:1] == 7'h58));
            bus_stop;
        end

        // R4 + R3: offset write; R7: commit and busy refusal.
        wr_xfer(8'hB0, 8'h0E, 16'h5A00, 1, "R4 offset write");
        check("R4 offset value", offset_val, 8'h5A);
        check("R7 busy after commit", nv_busy, 1);
        bus_start;
        send_byte(8'hB0, a);
        check("R7 address NACK while busy", a, 0);
        bus_stop;
        wait_idle;
        check("R7 busy ends", nv_busy, 0);
        rd_xfer(8'hB0, 8'h0E, 1, 24'h5A0000, "R6 offset read");

        // R5: level register staged, then both bytes at once.
        bus_start;
        send_byte(8'hB0, a); check("R3 level addr ack", a, 1);
        send_byte(8'h08, a); check("R3 level cmd ack", a, 1);
        send_byte(8'h12, a); check("R3 level msb ack", a, 1);
        tick(Q);
        check("R5 level unchanged after MSB", level_val, 16'h0000);
        send_byte(8'h34, a); check("R3 level lsb ack", a, 1);
        tick(2);
        check("R5 level after LSB", level_val, 16'h1234);
        bus_stop;
        check("R7 level commit busy", nv_busy, 1);
        wait_idle;
        rd_xfer(8'hB0, 8'h08, 3, 24'h1234FF, "R6 level read");

        // R8: truncated level write: no change, no commit.
        wr_xfer(8'hB0, 8'h08, 16'hAB00, 1, "R8 truncated");
        check("R8 truncated no commit", nv_busy, 0);
        check("R8 truncated level kept", level_val, 16'h1234);

        // R8: unknown command ACKed, discarded, reads FFh.
        wr_xfer(8'hB0, 8'h33, 16'h7700, 1, "R8 unknown");
        check("R8 unknown no commit", nv_busy, 0);
        check("R8 unknown offset kept", offset_val, 8'h5A);
        check("R8 unknown level kept", level_val, 16'h1234);
        rd_xfer(8'hB0, 8'h33, 1, 24'hFF0000, "R6 unknown read");

        // R4: device address register moves the match.
        wr_xfer(8'hB0, 8'h0D, 16'h0500, 1, "R4 addr write");
        check("R7 addr commit busy", nv_busy, 1);
        wait_idle;
        for (int d = 0; d < 8; d++) begin
            bus_start;
            send_byte({4'b1011, 3'(d), 1'b0}, a);
            check($sformatf("R4 new address sweep %0d", d), a, (d == 5));
            bus_stop;
        end
        rd_xfer(8'hBA, 8'h0D, 1, 24'h050000, "R4 addr read");
        check("R3 idle sda released", sda_pull, 0);

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule